// File: doc/BRIEF.md
# Reset Strap Configuration Latch

This block captures board strap values from the upper byte of an external data bus whenever a reset ends. It holds them as static configuration fields for the rest of the chip. Two reset sources re-arm the latch:

- **Hardware reset pin.** It is asynchronous. It is brought into the clock domain through a short synchronizer before its release is detected.
- **Soft reset bit.** It lives in a host-writable configuration register. Software sets the bit, and it stays set until software writes it back to zero. That write ends the soft reset and triggers a new capture.

The captured byte is split into several fields:

- a flag that stops the chip select from being mapped onto the nonvolatile flash;
- a flag that selects 16-bit wide external RAM and flash;
- an idle flag that holds firmware off, so that firmware can be downloaded first;
- a 3-bit field reserved for firmware use;
- two reserved bits, which are kept and reported as sampled.

The idle flag is forced clear for as long as the soft reset bit is set. A run-enable output tells the processor when it may execute: no reset source is active, no capture is pending, and the idle flag is clear.

Top module: `strap_latch`

## Requirements
- R1: While `hw_reset` is high, every latched field, `soft_rst` and `fw_run_en` read 0, without waiting for a clock edge.
- R2: After `hw_reset` falls, the strap bus is captured on the third rising clock edge. Fields read 0 after the second edge and the captured value after the third.
- R3: A write (`cfg_wr` high at a rising edge) loads `soft_rst` from bit 7 of `cfg_wdata`. Bits 6..0 of the write data have no effect. Without a write, `soft_rst` holds its value.
- R4: A write that clears `soft_rst` causes the strap bus to be captured on the next rising edge.
- R5: Field mapping of the strap bus `strap[7:0]`:
  - `strap[1]` drives `nv_map_dis`;
  - `strap[2]` drives `mem16_en`;
  - `strap[3]` drives `fw_idle`;
  - `strap[7:5]` drives `fw_field`;
  - `{strap[4], strap[0]}` drives `rsvd_bits`.
- R6: Between captures, changes on the strap bus have no effect on any field.
- R7: While `soft_rst` is set, `fw_idle` is cleared from the next rising edge onward.
- R8: `fw_run_en` is high only when no reset is active, no capture is pending and `fw_idle` is 0.
- R9: `hw_reset` clears `soft_rst`.
- R10: When both reset sources overlap, the capture happens only after the later one is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| hw_reset | input | 1 | Asynchronous hardware reset, active high |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration register write data; bit 7 is the soft reset |
| strap | input | 8 | Strap bus, data bits 15..8 |
| soft_rst | output | 1 | Current soft reset bit |
| nv_map_dis | output | 1 | Disable chip-select mapping to nonvolatile flash |
| mem16_en | output | 1 | External memory is 16 bits wide |
| fw_idle | output | 1 | Firmware execution inhibited |
| fw_field | output | 3 | Firmware-purpose strap field |
| rsvd_bits | output | 2 | Reserved straps as sampled |
| fw_run_en | output | 1 | Firmware may execute |

## Verification
The assertions check the following on every cycle:
- non-idle fields stay stable outside a capture cycle;
- each capture copies the bus bit by bit into the right fields;
- the soft reset bit moves only on a write;
- the idle flag is clear after any cycle with soft reset set;
- run enable never coexists with an active reset or a set idle flag.

Some behaviour only the bench scenarios can show. These are the exact edge count from the pin release to the capture, the overlap of the two reset sources, and the run-enable timing across a full soft reset sequence with varied strap patterns.

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int STRAP_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SOFT_BIT    = 7
) (
  input  logic               clk,
  input  logic               hw_reset,
  input  logic               cfg_wr,
  input  logic [7:0]         cfg_wdata,
  input  logic [STRAP_W-1:0] strap,
  output logic               soft_rst,
  output logic               nv_map_dis,
  output logic               mem16_en,
  output logic               fw_idle,
  output logic [2:0]         fw_field,
  output logic [1:0]         rsvd_bits,
  output logic               fw_run_en
);

  localparam int POS_RSV0 = 0;
  localparam int POS_NV   = 1;
  localparam int POS_M16  = 2;
  localparam int POS_IDLE = 3;
  localparam int POS_RSV1 = 4;
  localparam int POS_FW   = 5;

  logic [SYNC_STAGES-1:0] hw_sync;
  logic                   hw_act;
  logic                   soft_q;
  logic                   rst_prev;
  logic                   rst_any;
  logic                   sample;
  logic [STRAP_W-1:0]     strap_q;
  logic                   unused_wdata;

  assign unused_wdata = ^cfg_wdata[SOFT_BIT-1:0];

  always_ff @(posedge clk or posedge hw_reset)
    if (hw_reset) hw_sync <= '1;
    else          hw_sync <= {hw_sync[SYNC_STAGES-2:0], 1'b0};

  assign hw_act = hw_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or posedge hw_reset)
    if (hw_reset)    soft_q <= 1'b0;
    else if (cfg_wr) soft_q <= cfg_wdata[SOFT_BIT];

  assign rst_any = hw_act | soft_q;

  always_ff @(posedge clk or posedge hw_reset)
    if (hw_reset) rst_prev <= 1'b1;
    else          rst_prev <= rst_any;

  assign sample = rst_prev & ~rst_any;

  always_ff @(posedge clk or posedge hw_reset)
    if (hw_reset)    strap_q <= '0;
    else if (sample) strap_q <= strap;
    else if (soft_q) strap_q[POS_IDLE] <= 1'b0;

  assign soft_rst   = soft_q;
  assign nv_map_dis = strap_q[POS_NV];
  assign mem16_en   = strap_q[POS_M16];
  assign fw_idle    = strap_q[POS_IDLE];
  assign fw_field   = strap_q[POS_FW +: 3];
  assign rsvd_bits  = {strap_q[POS_RSV1], strap_q[POS_RSV0]};
  assign fw_run_en  = ~rst_any & ~rst_prev & ~strap_q[POS_IDLE];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    hw_reset |-> (!soft_rst && !fw_run_en && strap_q == '0));  // R1

  AST_SOFT_WRITE: assert property (@(posedge clk) disable iff (hw_reset)
    cfg_wr |=> (soft_rst == $past(cfg_wdata[SOFT_BIT])));  // R3

  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (hw_reset)
    !cfg_wr |=> $stable(soft_rst));  // R3

  AST_CAPTURE_MAP: assert property (@(posedge clk) disable iff (hw_reset)
    sample |=> (nv_map_dis == $past(strap[POS_NV]) && mem16_en == $past(strap[POS_M16])
                && fw_field == $past(strap[POS_FW +: 3])));  // R5

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (hw_reset)
    !sample |=> ($stable(nv_map_dis) && $stable(mem16_en) && $stable(fw_field)
                 && $stable(rsvd_bits)));  // R6

  AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (hw_reset)
    soft_rst |=> !fw_idle);  // R7

  AST_RUN_GATED: assert property (@(posedge clk) disable iff (hw_reset)
    fw_run_en |-> (!soft_rst && !fw_idle && !hw_act));  // R8

endmodule

// File: tb/tb_strap_latch.sv
module tb_strap_latch;
  logic       clk = 1'b0;
  logic       hw_reset;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] strap;
  logic       soft_rst, nv_map_dis, mem16_en, fw_idle, fw_run_en;
  logic [2:0] fw_field;
  logic [1:0] rsvd_bits;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  strap_latch dut (
    .clk(clk), .hw_reset(hw_reset), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .strap(strap), .soft_rst(soft_rst), .nv_map_dis(nv_map_dis),
    .mem16_en(mem16_en), .fw_idle(fw_idle), .fw_field(fw_field),
    .rsvd_bits(rsvd_bits), .fw_run_en(fw_run_en)
  );

  localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'h02, 8'h04, 8'h08, 8'hE0, 8'h11, 8'hA6};

  function automatic logic [7:0] pack_fields();
    return {fw_field, rsvd_bits, fw_idle, mem16_en, nv_map_dis};
  endfunction

  function automatic logic [7:0] expect_fields(input logic [7:0] s);
    return {s[7:5], s[4], s[0], s[3], s[2], s[1]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic soft_cycle(input logic [7:0] s);
    cfg_write(8'h80);
    strap = s;
    cfg_write(8'h00);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    hw_reset = 1'b1;
    cfg_wr = 1'b0;
    cfg_wdata = 8'h00;
    strap = 8'h5A;
    #1;
    check("R1 fields in reset", pack_fields(), 8'h00);
    check("R1 soft/run in reset", {6'b0, soft_rst, fw_run_en}, 8'h00);
    repeat (3) @(negedge clk);

    strap = 8'hB6;
    hw_reset = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 not yet captured after 2 edges", pack_fields(), 8'h00);
    check("R8 run low while capture pending", {7'b0, fw_run_en}, 8'h00);
    @(negedge clk);
    check("R2 captured on third edge", pack_fields(), expect_fields(8'hB6));
    check("R8 run high after hw release", {7'b0, fw_run_en}, 8'h01);

    foreach (VEC[i]) begin
      soft_cycle(VEC[i]);
      check($sformatf("R5 R4 vector %0d fields", i), pack_fields(), expect_fields(VEC[i]));
      check($sformatf("R8 vector %0d run", i), {7'b0, fw_run_en}, {7'b0, ~VEC[i][3]});
    end

    strap = 8'h00;
    repeat (4) @(negedge clk);
    check("R6 strap change ignored", pack_fields(), expect_fields(8'hA6));

    soft_cycle(8'h08);
    check("R5 idle captured", {7'b0, fw_idle}, 8'h01);
    cfg_write(8'h80);
    check("R3 soft bit set", {7'b0, soft_rst}, 8'h01);
    check("R8 run low in soft reset", {7'b0, fw_run_en}, 8'h00);
    @(negedge clk);
    check("R7 idle cleared in soft reset", {7'b0, fw_idle}, 8'h00);
    strap = 8'h04;
    repeat (3) @(negedge clk);
    check("R3 soft bit holds", {7'b0, soft_rst}, 8'h01);
    check("R6 no capture during soft reset", {7'b0, mem16_en}, 8'h00);
    cfg_write(8'h7F);
    check("R3 low bits ignored, bit7 clears", {7'b0, soft_rst}, 8'h00);
    @(negedge clk);
    check("R4 captured after clearing write", pack_fields(), expect_fields(8'h04));

    cfg_write(8'h80);
    hw_reset = 1'b1;
    #1;
    check("R9 hw reset clears soft bit", {7'b0, soft_rst}, 8'h00);
    check("R1 fields cleared async", pack_fields(), 8'h00);
    @(negedge clk);
    hw_reset = 1'b0;
    cfg_write(8'h80);
    strap = 8'h22;
    repeat (3) @(negedge clk);
    check("R10 no capture while soft still set", pack_fields(), 8'h00);
    cfg_write(8'h00);
    @(negedge clk);
    check("R10 capture after later release", pack_fields(), expect_fields(8'h22));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule